// File: doc/BRIEF.md
# Floating-Point Compare with Condition Flags

This block compares two IEEE 754 binary floating-point operands, either both single precision or both double precision, and reports the outcome as a four-bit N/Z/C/V condition code. The codes are chosen so that the integer condition tests a later conditional branch already has (equal, less-than, greater-or-equal, unordered and the rest) map onto the IEEE comparison predicates. It also reports an invalid-operation flag. That flag follows one of two rules, picked per request: a quiet compare or a signaling compare.

A request is one cycle with `valid_i` high, carrying both operands, the precision select and the compare variant. The result is registered. `done_o` pulses in the following cycle, and `nzcv_o` and `invalid_o` keep the last result until the next request. A new request may be presented in every cycle.

The control is a two-state machine. IDLE means no result is being reported. REPORT means a result is being presented with `done_o` high. The transitions are:
- IDLE goes to REPORT when `valid_i` is high, and stays in IDLE when it is low.
- REPORT stays in REPORT when `valid_i` is high, which is a back-to-back request.
- REPORT returns to IDLE when `valid_i` is low.

Top module: `fp_cmp_flags`

## Requirements
- R1: While reset is held and after its release, before any request, `done_o` is 0, `nzcv_o` is 4'b0000 and `invalid_o` is 0.
- R2: `done_o` is high exactly in the cycle after a cycle with `valid_i` high. `nzcv_o` and `invalid_o` change only in that cycle and otherwise keep their values.
- R3: `nzcv_o` is {N,Z,C,V}, with bit 3 = N. Less-than gives 4'b1000, equal gives 4'b0110, greater-than gives 4'b0010 and unordered gives 4'b0011.
- R4: A zero compares equal to any zero, whatever the sign of either.
- R5: Ordered operands, including infinities and subnormals, are ordered by value. Any negative value is below any positive value. Between two negative operands, the larger magnitude is the smaller value.
- R6: An operand with an all-ones exponent and a nonzero fraction is a NaN. If either operand is a NaN, the result is unordered.
- R7: With `signal_i` = 0 (quiet compare), `invalid_o` is raised only when an operand is a signaling NaN, meaning the top fraction bit is 0. A quiet NaN, with the top fraction bit 1, gives unordered and `invalid_o` = 0.
- R8: With `signal_i` = 1 (signaling compare), any NaN operand raises `invalid_o`. Ordered operands never raise `invalid_o` in either variant.
- R9: With `dbl_i` = 0, the operands are bits [31:0] in single format and bits [63:32] are ignored. With `dbl_i` = 1, the full 64 bits are double format.
- R10: Requests in consecutive cycles each produce their own result in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Request strobe; operands are sampled in this cycle |
| dbl_i | input | 1 | 1 = double precision, 0 = single precision in bits [31:0] |
| signal_i | input | 1 | 1 = signaling compare, 0 = quiet compare |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| done_o | output | 1 | Result strobe, one cycle after `valid_i` |
| nzcv_o | output | 4 | Condition code {N,Z,C,V} |
| invalid_o | output | 1 | Invalid-operation flag for the reported result |

## Verification
Two functions can land in the same cycle. The first is reporting one result with `done_o` high. The second is accepting the next request while REPORT stays in REPORT. The bench provokes this by issuing runs of requests with no gap between them and mixing precisions and compare variants within a run. A bench-side reference model registers its expected flags on every edge and is compared with the outputs on every clock, so a result that is late, dropped or taken from the wrong request shows up at once. Unordered outcomes, where the code and the invalid flag both depend on the NaN type and the compare variant, are judged in the same way inside these runs.

// File: rtl/fp_cmp_pkg.sv
package fp_cmp_pkg;

    localparam int OP_W      = 64;
    localparam int SP_EXP_W  = 8;
    localparam int SP_FRAC_W = 23;
    localparam int DP_EXP_W  = 11;
    localparam int DP_FRAC_W = 52;
    localparam int MAG_W     = DP_EXP_W + DP_FRAC_W;
    localparam int SP_W      = SP_EXP_W + SP_FRAC_W + 1;
    localparam int FLAG_W    = 4;

    localparam logic [FLAG_W-1:0] NZCV_LT = 4'b1000;
    localparam logic [FLAG_W-1:0] NZCV_EQ = 4'b0110;
    localparam logic [FLAG_W-1:0] NZCV_GT = 4'b0010;
    localparam logic [FLAG_W-1:0] NZCV_UN = 4'b0011;

    typedef enum logic [1:0] {
        REL_LT,
        REL_EQ,
        REL_GT,
        REL_UN
    } rel_e;

    typedef enum logic {
        ST_IDLE,
        ST_REPORT
    } state_e;

    typedef struct packed {
        logic             sign;
        logic             zero;
        logic             nan;
        logic             snan;
        logic [MAG_W-1:0] mag;
    } opnd_t;

endpackage

// File: rtl/fp_cmp_classify.sv
module fp_cmp_classify
    import fp_cmp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] enc_i,
    output opnd_t                 info_o
);
    localparam int BODY_W = EXP_W + FRAC_W;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_max;
    logic              frac_nz;

    assign exp_f   = enc_i[BODY_W-1:FRAC_W];
    assign frac_f  = enc_i[FRAC_W-1:0];
    assign exp_max = &exp_f;
    assign frac_nz = |frac_f;

    always_comb begin
        info_o                  = '0;
        info_o.sign             = enc_i[BODY_W];
        info_o.zero             = ~|enc_i[BODY_W-1:0];
        info_o.nan              = exp_max & frac_nz;
        info_o.snan             = exp_max & frac_nz & ~frac_f[FRAC_W-1];
        info_o.mag[BODY_W-1:0]  = enc_i[BODY_W-1:0];
    end

endmodule

// File: rtl/fp_cmp_front.sv
module fp_cmp_front
    import fp_cmp_pkg::*;
(
    input  logic [OP_W-1:0] a_i,
    input  logic [OP_W-1:0] b_i,
    input  logic            dbl_i,
    output opnd_t           info_a_o,
    output opnd_t           info_b_o
);
    localparam int N_OPS = 2;

    logic [OP_W-1:0] ops  [N_OPS];
    opnd_t           info [N_OPS];

    assign ops[0] = a_i;
    assign ops[1] = b_i;

    for (genvar i = 0; i < N_OPS; i++) begin : g_opnd
        opnd_t sp_info;
        opnd_t dp_info;

        fp_cmp_classify #(
            .EXP_W  (SP_EXP_W),
            .FRAC_W (SP_FRAC_W)
        ) u_sp (
            .enc_i  (ops[i][SP_W-1:0]),
            .info_o (sp_info)
        );

        fp_cmp_classify #(
            .EXP_W  (DP_EXP_W),
            .FRAC_W (DP_FRAC_W)
        ) u_dp (
            .enc_i  (ops[i]),
            .info_o (dp_info)
        );

        assign info[i] = dbl_i ? dp_info : sp_info;
    end

    assign info_a_o = info[0];
    assign info_b_o = info[1];

endmodule

// File: rtl/fp_cmp_order.sv
module fp_cmp_order
    import fp_cmp_pkg::*;
(
    input  opnd_t a_i,
    input  opnd_t b_i,
    output rel_e  rel_o,
    output logic  any_nan_o,
    output logic  any_snan_o
);
    logic mag_lt;
    logic mag_eq;

    assign mag_lt     = a_i.mag < b_i.mag;
    assign mag_eq     = a_i.mag == b_i.mag;
    assign any_nan_o  = a_i.nan | b_i.nan;
    assign any_snan_o = a_i.snan | b_i.snan;

    always_comb begin
        if (any_nan_o) begin
            rel_o = REL_UN;
        end else if (a_i.zero && b_i.zero) begin
            rel_o = REL_EQ;
        end else if (a_i.sign != b_i.sign) begin
            rel_o = a_i.sign ? REL_LT : REL_GT;
        end else if (mag_eq) begin
            rel_o = REL_EQ;
        end else if (mag_lt ^ a_i.sign) begin
            rel_o = REL_LT;
        end else begin
            rel_o = REL_GT;
        end
    end

endmodule

// File: rtl/fp_cmp_ctrl.sv
module fp_cmp_ctrl
    import fp_cmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic              signal_i,
    input  rel_e              rel_i,
    input  logic              any_nan_i,
    input  logic              any_snan_i,
    output logic              done_o,
    output logic [FLAG_W-1:0] nzcv_o,
    output logic              invalid_o
);
    state_e state_q;
    state_e state_d;
    logic   inv_d;

    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = valid_i ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_d = valid_i ? ST_REPORT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign inv_d = signal_i ? any_nan_i : any_snan_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nzcv_o    <= '0;
            invalid_o <= 1'b0;
        end else if (valid_i) begin
            invalid_o <= inv_d;
            unique case (rel_i)
                REL_LT:  nzcv_o <= NZCV_LT;
                REL_EQ:  nzcv_o <= NZCV_EQ;
                REL_GT:  nzcv_o <= NZCV_GT;
                REL_UN:  nzcv_o <= NZCV_UN;
                default: nzcv_o <= NZCV_UN;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            ST_REPORT: done_o = 1'b1;
            default:   done_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/fp_cmp_flags.sv
module fp_cmp_flags
    import fp_cmp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        valid_i,
    input  logic        dbl_i,
    input  logic        signal_i,
    input  logic [63:0] a_i,
    input  logic [63:0] b_i,
    output logic        done_o,
    output logic [3:0]  nzcv_o,
    output logic        invalid_o
);
    opnd_t info_a;
    opnd_t info_b;
    rel_e  rel;
    logic  any_nan;
    logic  any_snan;

    fp_cmp_front u_front (
        .a_i      (a_i),
        .b_i      (b_i),
        .dbl_i    (dbl_i),
        .info_a_o (info_a),
        .info_b_o (info_b)
    );

    fp_cmp_order u_order (
        .a_i        (info_a),
        .b_i        (info_b),
        .rel_o      (rel),
        .any_nan_o  (any_nan),
        .any_snan_o (any_snan)
    );

    fp_cmp_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_i    (valid_i),
        .signal_i   (signal_i),
        .rel_i      (rel),
        .any_nan_i  (any_nan),
        .any_snan_i (any_snan),
        .done_o     (done_o),
        .nzcv_o     (nzcv_o),
        .invalid_o  (invalid_o)
    );

endmodule

// File: rtl/fp_cmp_flags_chk.sv
module fp_cmp_flags_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        valid_i,
    input logic        dbl_i,
    input logic        signal_i,
    input logic [63:0] a_i,
    input logic [63:0] b_i,
    input logic        done_o,
    input logic [3:0]  nzcv_o,
    input logic        invalid_o
);
    logic a_sp_nan;
    logic a_dp_nan;

    assign a_sp_nan = (a_i[30:23] == 8'hFF) && (a_i[22:0] != '0);
    assign a_dp_nan = (a_i[62:52] == 11'h7FF) && (a_i[51:0] != '0);

    assert_done_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> done_o);

    assert_no_spurious_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !done_o);

    assert_flags_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> ($stable(nzcv_o) && $stable(invalid_o)));

    assert_legal_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (nzcv_o == 4'b1000 || nzcv_o == 4'b0110 ||
                    nzcv_o == 4'b0010 || nzcv_o == 4'b0011));

    assert_zeros_equal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && dbl_i && a_i[62:0] == '0 && b_i[62:0] == '0) |=> nzcv_o == 4'b0110);

    assert_nan_unordered_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !dbl_i && a_sp_nan) |=> nzcv_o == 4'b0011);

    assert_invalid_only_unordered_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && invalid_o) |-> nzcv_o == 4'b0011);

    assert_signaling_any_nan_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && signal_i && dbl_i && a_dp_nan) |=> invalid_o);

endmodule

bind fp_cmp_flags fp_cmp_flags_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_i   (valid_i),
    .dbl_i     (dbl_i),
    .signal_i  (signal_i),
    .a_i       (a_i),
    .b_i       (b_i),
    .done_o    (done_o),
    .nzcv_o    (nzcv_o),
    .invalid_o (invalid_o)
);

// File: tb/tb_fp_cmp_flags.sv
`timescale 1ns/1ps
module tb_fp_cmp_flags;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic        dbl_i = 1'b0;
    logic        signal_i = 1'b0;
    logic [63:0] a_i = '0;
    logic [63:0] b_i = '0;
    logic        done_o;
    logic [3:0]  nzcv_o;
    logic        invalid_o;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    finished = 1'b0;
    string cur_req  = "R2";

    logic        m_done = 1'b0;
    logic [3:0]  m_nzcv = '0;
    logic        m_inv  = 1'b0;
    string       m_req  = "R2";

    always #4 clk = ~clk;

    fp_cmp_flags dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_i   (valid_i),
        .dbl_i     (dbl_i),
        .signal_i  (signal_i),
        .a_i       (a_i),
        .b_i       (b_i),
        .done_o    (done_o),
        .nzcv_o    (nzcv_o),
        .invalid_o (invalid_o)
    );

    function automatic logic [4:0] ref_cmp(logic [63:0] a, logic [63:0] b,
                                           logic dbl, logic sig);
        logic na, nb, sna, snb, sa, sb;
        logic [62:0] ka, kb;
        logic signed [64:0] va, vb;
        logic [3:0] code;
        logic inv;
        if (dbl) begin
            na  = (a[62:52] == 11'h7FF) && (a[51:0] != 0);
            nb  = (b[62:52] == 11'h7FF) && (b[51:0] != 0);
            sna = na && !a[51];
            snb = nb && !b[51];
            sa = a[63]; sb = b[63];
            ka = a[62:0]; kb = b[62:0];
        end else begin
            na  = (a[30:23] == 8'hFF) && (a[22:0] != 0);
            nb  = (b[30:23] == 8'hFF) && (b[22:0] != 0);
            sna = na && !a[22];
            snb = nb && !b[22];
            sa = a[31]; sb = b[31];
            ka = {32'b0, a[30:0]}; kb = {32'b0, b[30:0]};
        end
        va = $signed({2'b00, ka});
        vb = $signed({2'b00, kb});
        if (sa) va = -va;
        if (sb) vb = -vb;
        if (na || nb)      code = 4'b0011;
        else if (va < vb)  code = 4'b1000;
        else if (va == vb) code = 4'b0110;
        else               code = 4'b0010;
        inv = sig ? (na || nb) : (sna || snb);
        return {inv, code};
    endfunction

    always @(posedge clk) begin
        if (rst_n) begin
            m_done <= valid_i;
            if (valid_i) begin
                {m_inv, m_nzcv} <= ref_cmp(a_i, b_i, dbl_i, signal_i);
                m_req <= cur_req;
            end
        end
    end

    task automatic check(logic ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(done_o === m_done, "R2", "done", 64'(done_o), 64'(m_done));
            check(nzcv_o === m_nzcv, m_req, "nzcv", 64'(nzcv_o), 64'(m_nzcv));
            check(invalid_o === m_inv, m_req, "invalid", 64'(invalid_o), 64'(m_inv));
        end
    end

    task automatic req(logic [63:0] a, logic [63:0] b, logic dbl, logic sig, string r);
        @(negedge clk);
        a_i = a; b_i = b; dbl_i = dbl; signal_i = sig; valid_i = 1'b1; cur_req = r;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            valid_i = 1'b0;
            a_i = 64'hDEAD_BEEF_0BAD_F00D;
            b_i = 64'h7FF8_0000_0000_0001;
            cur_req = "R2";
        end
    endtask

    localparam logic [63:0] S_ONE  = 64'h3F80_0000, S_TWO  = 64'h4000_0000;
    localparam logic [63:0] S_MONE = 64'hBF80_0000, S_MTWO = 64'hC000_0000;
    localparam logic [63:0] S_PZ   = 64'h0000_0000, S_NZ   = 64'h8000_0000;
    localparam logic [63:0] S_INF  = 64'h7F80_0000, S_NINF = 64'hFF80_0000;
    localparam logic [63:0] S_QNAN = 64'h7FC0_0000, S_SNAN = 64'h7F80_0001;
    localparam logic [63:0] S_SUB1 = 64'h0000_0001, S_SUB2 = 64'h0000_0002;
    localparam logic [63:0] S_MAX  = 64'h7F7F_FFFF, S_NSUB = 64'h8000_0001;
    localparam logic [63:0] D_ONE  = 64'h3FF0_0000_0000_0000, D_TWO = 64'h4000_0000_0000_0000;
    localparam logic [63:0] D_MONE = 64'hBFF0_0000_0000_0000, D_NZ  = 64'h8000_0000_0000_0000;
    localparam logic [63:0] D_NINF = 64'hFFF0_0000_0000_0000, D_INF = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] D_QNAN = 64'h7FF8_0000_0000_0000, D_SNAN = 64'h7FF0_0000_0000_0001;
    localparam logic [63:0] D_SUB  = 64'h0000_0000_0000_0001;

    initial begin
        repeat (3) @(negedge clk);
        check(done_o === 1'b0 && nzcv_o === 4'b0000 && invalid_o === 1'b0, "R1",
              "reset state", {59'b0, done_o, nzcv_o}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done_o === 1'b0 && nzcv_o === 4'b0000 && invalid_o === 1'b0, "R1",
              "after release", {59'b0, done_o, nzcv_o}, 64'h0);

        req(S_ONE, S_TWO, 0, 0, "R3");
        idle(2);
        req(S_TWO, S_ONE, 0, 0, "R3");
        req(S_ONE, S_ONE, 0, 0, "R3");
        idle(1);
        req(S_PZ, S_NZ, 0, 0, "R4");
        req(S_NZ, S_PZ, 0, 1, "R4");
        req(D_NZ, 64'h0, 1, 0, "R4");
        req(S_NZ, S_SUB1, 0, 0, "R4");
        idle(1);
        req(S_MONE, S_MTWO, 0, 0, "R5");
        req(S_MTWO, S_MONE, 0, 0, "R5");
        req(S_MONE, S_ONE, 0, 0, "R5");
        req(S_NINF, S_MTWO, 0, 0, "R5");
        req(S_INF, S_MAX, 0, 0, "R5");
        req(S_SUB1, S_SUB2, 0, 0, "R5");
        req(S_NSUB, S_PZ, 0, 0, "R5");
        req(D_MONE, D_ONE, 1, 0, "R5");
        req(D_SUB, D_NINF, 1, 1, "R5");
        req(D_INF, D_INF, 1, 1, "R5");
        idle(2);
        req(S_QNAN, S_ONE, 0, 0, "R6");
        req(S_ONE, S_SNAN, 0, 0, "R6");
        req(S_QNAN, S_QNAN, 0, 0, "R7");
        req(D_QNAN, D_ONE, 1, 0, "R7");
        req(D_ONE, D_SNAN, 1, 0, "R7");
        req(S_SNAN, S_QNAN, 0, 0, "R7");
        idle(1);
        req(S_QNAN, S_ONE, 0, 1, "R8");
        req(D_QNAN, D_TWO, 1, 1, "R8");
        req(D_SNAN, D_SNAN, 1, 1, "R8");
        req(S_ONE, S_TWO, 0, 1, "R8");
        idle(1);
        req({32'hFFFF_FFFF, S_ONE[31:0]}, {32'h1234_5678, S_TWO[31:0]}, 0, 0, "R9");
        req(D_SNAN, S_PZ, 0, 1, "R9");
        req(D_SNAN, S_PZ, 1, 0, "R9");
        req(64'h0000_0000_7F80_0000, 64'h0, 1, 0, "R9");
        for (int i = 0; i < 16; i++) begin
            req({32'(i * 7), 32'h3F80_0000 + 32'(i)}, {32'h0, 32'h3F80_0008}, i[0], i[1], "R10");
        end
        idle(4);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule